// File: doc/BRIEF.md
# DS3 Receive Alarm Consequent-Action Controller

This block sits beside a DS3 receive framer. It takes the framer's defect flags (loss of signal, out of frame, severely errored frame and incoming AIS) and a one-pulse-per-millisecond tick. From these it builds the alarm consequences that the rest of the chip acts on. It integrates out-of-frame into a loss-of-frame flag over a selectable time. It raises a request to replace the downstream payload with AIS. It raises a request to clear the transmit X-bits as a remote defect indication, and each defect has its own gate into that request.

A control level lets software force the framer to resynchronize. Each rising edge of that level gives one single-cycle pulse toward the framer, which forces out-of-frame and severely errored frame. The same edge loads a four-deep history of M-bit check results with all failures, so the out-of-multiframe flag asserts with it. Frame search, X-bit insertion and AIS pattern generation are handled elsewhere.

Top module: `ds3_alarm_action`

## Requirements
- R1: When `ais_auto_off` is 0, `ais_req` equals LOS OR OOF OR incoming AIS, as sampled at the previous rising clock edge.
- R2: When `ais_auto_off` was 1 at the previous edge, `ais_req` is 0 whatever the defect inputs are.
- R3: `lof_sel` encoding: 2'b00 needs 3 ticks, 2'b01 needs 2 ticks and 2'b10 needs 1 tick. A tick counts only in a cycle where `oof_in` is 1. `lof_out` rises one cycle after the clock edge that registers the last needed tick, provided `oof_in` has been 1 without a break since the count began.
- R4: When `lof_sel` is 2'b11, `lof_out` follows `oof_in` with a one-cycle delay. No tick is needed.
- R5: `lof_out` falls one cycle after `oof_in` falls, and the tick count restarts from zero. Ticks collected before an OOF gap do not count afterwards.
- R6: The LOF term enters `rdi_req` only when `rdi_lof_en` is 1 (enable polarity). `rdi_req` is registered, so it rises in the same cycle as `lof_out`.
- R7: The LOS, SEF and AIS terms each enter `rdi_req` only when their own control bit (`rdi_los_off`, `rdi_sef_off`, `rdi_ais_off`) is 0 (disable polarity). Each term takes effect one cycle after it is sampled.
- R8: When `tx_auto_rdi_en` was 0 at the previous edge, `rdi_req` is 0.
- R9: A 0-to-1 change of `resync_ctl` gives `resync_pulse` = 1 for exactly one cycle, starting one cycle after the edge that first samples the control high. Holding the control high gives no further pulse. A level that is already high when reset is released gives no pulse.
- R10: `oomf_out` is 1 exactly when the four most recent M-bit check results are all failures. Each cycle with `mchk_valid` = 1 shifts in `mchk_fail` (1 = failed). In the cycle after a `resync_pulse`, the history is loaded with four failures, so `oomf_out` is 1 in the cycle after the pulse.
- R11: During reset and in the first cycle after it, `ais_req`, `rdi_req`, `lof_out`, `resync_pulse` and `oomf_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| los_in | input | 1 | Loss of signal from framer |
| oof_in | input | 1 | Out of frame from framer |
| sef_in | input | 1 | Severely errored frame from framer |
| ais_in | input | 1 | Incoming AIS detected |
| mchk_valid | input | 1 | An M-bit check result is present |
| mchk_fail | input | 1 | That M-bit check failed |
| ais_auto_off | input | 1 | 1 blocks automatic downstream AIS |
| rdi_lof_en | input | 1 | 1 lets LOF drive the RDI request |
| rdi_los_off | input | 1 | 1 keeps LOS out of the RDI request |
| rdi_sef_off | input | 1 | 1 keeps SEF out of the RDI request |
| rdi_ais_off | input | 1 | 1 keeps AIS out of the RDI request |
| tx_auto_rdi_en | input | 1 | Transmit automatic RDI enabled |
| lof_sel | input | 2 | LOF integration select |
| resync_ctl | input | 1 | Resync control level (rising edge acts) |
| ais_req | output | 1 | Downstream AIS insertion request |
| rdi_req | output | 1 | Force transmit X-bits to zero |
| lof_out | output | 1 | Loss of frame |
| resync_pulse | output | 1 | Forces OOF and SEF in the framer |
| oomf_out | output | 1 | Out of multiframe |

## Verification
A wrong tick count or an integration counter that fails to clear shows on `lof_out` at the wrong cycle after the last tick, or after an OOF gap. The sweeps catch it at that very cycle. A wrong gate polarity shows on `rdi_req` one cycle after the defect pattern that exposes it. The full sweep of defects, gates and the transmit enable reaches every such pattern. A stale edge register shows as a missing or repeated `resync_pulse`. A wrong history shows on `oomf_out` at the first check after a resync or after four failures.

// File: rtl/ds3aa_pkg.sv
// Package: shared types for the DS3 alarm consequent-action block.
// Assumes the integration select is a two-bit field whose code 2'b11 means "no wait".
package ds3aa_pkg;

    typedef enum logic [1:0] {
        LOF_WAIT3 = 2'b00,
        LOF_WAIT2 = 2'b01,
        LOF_WAIT1 = 2'b10,
        LOF_NOW   = 2'b11
    } lof_sel_e;

    // Millisecond ticks an integration select needs before LOF is declared.
    function automatic int unsigned ticks_needed(lof_sel_e s);
        case (s)
            LOF_WAIT3: return 3;
            LOF_WAIT2: return 2;
            LOF_WAIT1: return 1;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/ds3aa_lof_integ.sv
// LOF integrator: counts millisecond ticks while OOF holds. It declares LOF once the
// selected count is reached, or at once for the no-wait select.
// Assumes tick is a single-cycle pulse. The count saturates at its all-ones value.
module ds3aa_lof_integ
    import ds3aa_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     oof,
    input  lof_sel_e sel,
    output logic     lof_next,
    output logic     lof_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] need;

    assign need = CNT_W'(ticks_needed(sel));

    // Tick counter: clears whenever OOF is absent, advances on each tick while OOF holds.
    always_ff @(posedge clk) begin
        if (!rst_n || !oof)
            cnt_q <= '0;
        else if (tick && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    // Next LOF: OOF present and either no wait is selected or the count is reached.
    always_comb begin
        lof_next = oof && ((sel == LOF_NOW) || (cnt_q >= need));
    end

    // LOF register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lof_q <= 1'b0;
        else
            lof_q <= lof_next;
    end
endmodule

// File: rtl/ds3aa_resync_edge.sv
// Resync edge detector: turns a 0-to-1 change of a control level into one
// registered force pulse.
// Assumes the control is synchronous to clk. The history register resets to 1,
// so a level already high at reset release is not treated as an edge.
module ds3aa_resync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl,
    output logic pulse_q
);
    logic ctl_d;

    // Sample the control each clock and register the rising-edge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_d   <= 1'b1;
            pulse_q <= 1'b0;
        end else begin
            ctl_d   <= ctl;
            pulse_q <= ctl && !ctl_d;
        end
    end
endmodule

// File: rtl/ds3aa_mbit_hist.sv
// M-bit check history: keeps the most recent DEPTH check outcomes. It flags
// out-of-multiframe when every one of them failed. A force input loads all failures.
// Assumes force takes priority over a check that arrives in the same cycle.
module ds3aa_mbit_hist #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_fail,
    input  logic chk_valid,
    input  logic chk_fail,
    output logic oomf_q
);
    logic [DEPTH-1:0] hist_q;
    logic [DEPTH-1:0] hist_d;

    // Next history: load all failures on force, otherwise shift in a valid outcome.
    always_comb begin
        hist_d = hist_q;
        if (force_fail)
            hist_d = '1;
        else if (chk_valid)
            hist_d = {hist_q[DEPTH-2:0], chk_fail};
    end

    // History and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            oomf_q <= 1'b0;
        end else begin
            hist_q <= hist_d;
            oomf_q <= &hist_d;
        end
    end
endmodule

// File: rtl/ds3_alarm_action.sv
// Top: DS3 receive alarm consequent actions. Builds the downstream AIS request and
// the per-defect-gated RDI request, integrates OOF into LOF, and handles forced
// resynchronization.
// Assumes all inputs are synchronous to clk. All outputs are registered.
module ds3_alarm_action
    import ds3aa_pkg::*;
#(
    parameter int LOF_CNT_W  = 2,
    parameter int MHIST_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1ms,
    input  logic       los_in,
    input  logic       oof_in,
    input  logic       sef_in,
    input  logic       ais_in,
    input  logic       mchk_valid,
    input  logic       mchk_fail,
    input  logic       ais_auto_off,
    input  logic       rdi_lof_en,
    input  logic       rdi_los_off,
    input  logic       rdi_sef_off,
    input  logic       rdi_ais_off,
    input  logic       tx_auto_rdi_en,
    input  logic [1:0] lof_sel,
    input  logic       resync_ctl,
    output logic       ais_req,
    output logic       rdi_req,
    output logic       lof_out,
    output logic       resync_pulse,
    output logic       oomf_out
);
    logic lof_next;
    logic ais_d;
    logic rdi_d;

    ds3aa_lof_integ #(.CNT_W(LOF_CNT_W)) u_lof (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1ms),
        .oof      (oof_in),
        .sel      (lof_sel_e'(lof_sel)),
        .lof_next (lof_next),
        .lof_q    (lof_out)
    );

    ds3aa_resync_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (resync_ctl),
        .pulse_q (resync_pulse)
    );

    ds3aa_mbit_hist #(.DEPTH(MHIST_DEPTH)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_fail (resync_pulse),
        .chk_valid  (mchk_valid),
        .chk_fail   (mchk_fail),
        .oomf_q     (oomf_out)
    );

    // Request terms: AIS from any signal-level defect; RDI from each gated defect.
    always_comb begin
        ais_d = !ais_auto_off && (los_in || oof_in || ais_in);
        rdi_d = tx_auto_rdi_en &&
                ((rdi_lof_en   && lof_next) ||
                 (!rdi_los_off && los_in)   ||
                 (!rdi_sef_off && sef_in)   ||
                 (!rdi_ais_off && ais_in));
    end

    // Register both requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ais_req <= 1'b0;
            rdi_req <= 1'b0;
        end else begin
            ais_req <= ais_d;
            rdi_req <= rdi_d;
        end
    end
endmodule

// File: rtl/ds3aa_chk.sv
// Checker for ds3_alarm_action: port-level timing properties. It is attached with bind.
// Assumes a synchronous active-low reset. past_ok blocks $past before a full cycle out of reset.
module ds3aa_chk (
    input logic clk,
    input logic rst_n,
    input logic ais_auto_off,
    input logic los_in,
    input logic oof_in,
    input logic ais_in,
    input logic tx_auto_rdi_en,
    input logic ais_req,
    input logic rdi_req,
    input logic lof_out,
    input logic resync_pulse,
    input logic oomf_out
);
    logic past_ok;

    // Marks that at least one clock edge has passed with reset released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            past_ok <= 1'b0;
        else
            past_ok <= 1'b1;
    end

    a_r1_ais_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!ais_auto_off && (los_in || oof_in || ais_in))) |-> ais_req);

    a_r2_ais_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ais_auto_off)) |-> !ais_req);

    a_r5_lof_needs_oof: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && lof_out) |-> $past(oof_in));

    a_r8_rdi_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(tx_auto_rdi_en)) |-> !rdi_req);

    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        resync_pulse |=> !resync_pulse);

    a_r10_oomf_after_force: assert property (@(posedge clk) disable iff (!rst_n)
        resync_pulse |=> oomf_out);
endmodule

bind ds3_alarm_action ds3aa_chk u_chk (.*);

// File: tb/sim_ds3_alarm_action.sv
`timescale 1ns/1ps
module sim_ds3_alarm_action;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1ms = 0, los_in = 0, oof_in = 0, sef_in = 0, ais_in = 0;
    logic mchk_valid = 0, mchk_fail = 0;
    logic ais_auto_off = 0, rdi_lof_en = 0, rdi_los_off = 0, rdi_sef_off = 0, rdi_ais_off = 0;
    logic tx_auto_rdi_en = 0;
    logic [1:0] lof_sel = 2'b11;
    logic resync_ctl = 0;
    logic ais_req, rdi_req, lof_out, resync_pulse, oomf_out;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ds3_alarm_action u0 (.*);

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11 reset state, with the resync level held high through reset (R9)
        resync_ctl = 1;
        cyc(3);
        chk("R11 ais", ais_req, 0); chk("R11 rdi", rdi_req, 0);
        chk("R11 lof", lof_out, 0); chk("R11 pulse", resync_pulse, 0);
        chk("R11 oomf", oomf_out, 0);
        rst_n = 1;
        cyc(1);
        chk("R9 no pulse from level high at reset", resync_pulse, 0);
        chk("R11 oomf after release", oomf_out, 0);
        cyc(2);
        chk("R9 no pulse while held", resync_pulse, 0);
        resync_ctl = 0;
        cyc(2);

        // R1/R2 sweep over the AIS control and the three AIS sources
        for (int v = 0; v < 16; v++) begin
            ais_auto_off = v[3]; los_in = v[2]; oof_in = v[1]; ais_in = v[0];
            cyc(1);
            if (v[3]) chk("R2 ais blocked", ais_req, 0);
            else chk("R1 ais request", ais_req, v[2] | v[1] | v[0]);
        end
        ais_auto_off = 0; los_in = 0; oof_in = 0; ais_in = 0;
        cyc(2);

        // R4/R6/R7/R8 sweep with the no-wait select so LOF follows OOF
        lof_sel = 2'b11;
        for (int v = 0; v < 512; v++) begin
            logic e;
            los_in = v[0]; oof_in = v[1]; sef_in = v[2]; ais_in = v[3];
            rdi_lof_en = v[4]; rdi_los_off = v[5]; rdi_sef_off = v[6]; rdi_ais_off = v[7];
            tx_auto_rdi_en = v[8];
            e = v[8] & ((v[4] & v[1]) | (~v[5] & v[0]) | (~v[6] & v[2]) | (~v[7] & v[3]));
            cyc(1);
            chk("R6 R7 R8 rdi request", rdi_req, e);
            chk("R4 lof no wait", lof_out, v[1]);
        end
        los_in = 0; oof_in = 0; sef_in = 0; ais_in = 0;
        rdi_lof_en = 1; rdi_los_off = 1; rdi_sef_off = 1; rdi_ais_off = 1; tx_auto_rdi_en = 1;
        cyc(2);

        // R3/R5 integration for each timed select
        for (int s = 0; s < 3; s++) begin
            int need;
            need = 3 - s;
            lof_sel = 2'(s);
            // An interrupted run must restart its count (R5)
            oof_in = 1;
            for (int k = 0; k < need - 1; k++) begin
                tick_1ms = 1; cyc(1); tick_1ms = 0; cyc(1);
            end
            oof_in = 0; cyc(1);
            chk("R5 lof low after gap", lof_out, 0);
            oof_in = 1;
            for (int k = 0; k < need - 1; k++) begin
                tick_1ms = 1; cyc(1); tick_1ms = 0; cyc(1);
                chk("R5 restart no early lof", lof_out, 0);
            end
            tick_1ms = 1; cyc(1); tick_1ms = 0;
            chk("R3 lof not yet", lof_out, 0);
            cyc(1);
            chk("R3 lof declared", lof_out, 1);
            chk("R6 rdi with lof", rdi_req, 1);
            cyc(3);
            chk("R3 lof holds", lof_out, 1);
            oof_in = 0; cyc(1);
            chk("R5 lof clears", lof_out, 0);
            cyc(1);
        end
        lof_sel = 2'b11;
        rdi_lof_en = 0;

        // R9/R10 forced resync and history
        for (int r = 0; r < 2; r++) begin
            resync_ctl = 1; cyc(1);
            chk("R9 pulse", resync_pulse, 1);
            chk("R10 oomf before load", oomf_out, 0);
            cyc(1);
            chk("R9 pulse single", resync_pulse, 0);
            chk("R10 oomf after force", oomf_out, 1);
            cyc(3);
            chk("R9 held high no pulse", resync_pulse, 0);
            mchk_valid = 1; mchk_fail = 0; cyc(1); mchk_valid = 0;
            chk("R10 pass clears oomf", oomf_out, 0);
            for (int k = 0; k < 4; k++) begin
                mchk_valid = 1; mchk_fail = 1; cyc(1); mchk_valid = 0;
                chk("R10 four failures", oomf_out, k == 3);
                cyc(1);
                chk("R10 no change without valid", oomf_out, k == 3);
            end
            mchk_valid = 1; mchk_fail = 0; cyc(1); mchk_valid = 0;
            chk("R10 pass clears again", oomf_out, 0);
            resync_ctl = 0; cyc(2);
            chk("R9 no pulse on fall", resync_pulse, 0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule